// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Switch Network

This block connects N input ports to N output ports (N a power of two) through log2 N columns of 2×2 switching elements. In front of every column, the lines are rewired so that line address `a` feeds element input `rotl(a)`, a one-bit left rotation. Each input offers a valid flag, a destination index and a payload word. The packet finds its own way through the network: each column reads one bit of the destination index and sends the packet to the upper or lower output of its element. After the last column, every packet that was not stopped sits on the output whose index equals its destination.

Two packets can meet in one element and ask for the same output. In that case a one-bit round-robin pointer inside the element picks the one that goes on. The other packet is dropped, and a blocked flag is raised for the source port it came from. Nothing is retried or queued. A register stage sits at the inputs and another at the outputs, with the switching logic purely combinational between them. Results therefore appear two clock edges after the inputs are sampled.

Top module: `omega_network`

## Requirements
- R1: While reset is low at a clock edge, after that edge all `out_valid`, `out_data` and `in_blocked` bits are zero, and every element's round-robin pointer favours its upper input.
- R2: Inputs sampled at clock edge k produce outputs visible after edge k+1. After edge k alone, those inputs have no effect on the outputs.
- R3: When no two valid packets compete for an element output, every valid input p with destination index t raises `out_valid[t]` and delivers its payload unchanged on `out_data[t*DATA_W +: DATA_W]`.
- R4: Column s (s=0 is the first) steers on destination bit log2N-1-s, so the MSB steers first and the LSB steers last. Bit value 0 selects the element's upper output (even line) and 1 selects its lower output (odd line). Before each column, line a moves to line rotl(a).
- R5: When two valid packets in one element request the same output, exactly one proceeds. The other is discarded, and the bit of `in_blocked` for its source port is set in the same cycle as the outputs of that input vector.
- R6: Each element's pointer picks the upper input when it is 0 and the lower input when it is 1. The pointer toggles after every conflict that element resolves, and at no other time.
- R7: Inputs whose valid bit is 0 are ignored: their destination and payload reach no output, raise no blocked flag and change no pointer.
- R8: `out_data` for an output port is all zero whenever that port's `out_valid` bit is 0.
- R9: For each input vector, every valid input is either delivered to exactly one output or flagged blocked, never both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | N_PORTS | Per-input packet present |
| in_tag | input | N_PORTS*log2(N_PORTS) | Per-input destination index, port p at bits p*log2N +: log2N |
| in_data | input | N_PORTS*DATA_W | Per-input payload, port p at bits p*DATA_W +: DATA_W |
| out_valid | output | N_PORTS | Per-output packet arrived |
| out_data | output | N_PORTS*DATA_W | Per-output payload, zero when not valid |
| in_blocked | output | N_PORTS | Per-source flag: packet lost arbitration |

## Verification
Every result is due two edges after its input vector is sampled: one edge for the input register and one for the output register. The bench drives each vector on a falling edge. One cycle later it changes the inputs to an idle vector that still carries the old destination bits, and checks that the outputs are still idle. One cycle after that it compares delivery, payload and blocked flags against its own model of the network. That model computes each packet's line position column by column with closed-form shift arithmetic and keeps a pointer per element. Directed vectors force a repeated conflict between one pair of sources, separated by an invalid look-alike, to show the pointer alternates and is untouched by invalid inputs.

// File: rtl/omega_pkg.sv
// Package: shared helpers for the shuffle-exchange network.
// Assumes line counts are powers of two and addresses fit in an int.
package omega_pkg;

    // Which input of a 2x2 element wins a conflict
    typedef enum logic {
        PICK_UPPER = 1'b0,
        PICK_LOWER = 1'b1
    } rr_pick_e;

    // Source line feeding element-side line q after the shuffle wiring:
    // line a drives line rotl(a), so line q is fed from rotr(q).
    function automatic int shuffle_from(input int q, input int lg);
        return (q >> 1) | ((q & 1) << (lg - 1));
    endfunction

endpackage

// File: rtl/omega_switch2.sv
// Module: one 2x2 self-steering element.
// Reads bit BIT of each packet's destination index: 0 goes to y0 (upper),
// 1 goes to y1 (lower). When both valid packets want the same output, a
// one-bit pointer chooses the winner and toggles; the loser is flagged.
// Assumes packet layout {valid, src, tag, data}.
module omega_switch2
    import omega_pkg::*;
#(
    parameter int DW  = 8,
    parameter int LG  = 3,
    parameter int BIT = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*LG+DW:0]      a_pkt,
    input  logic [2*LG+DW:0]      b_pkt,
    output logic [2*LG+DW:0]      y0_pkt,
    output logic [2*LG+DW:0]      y1_pkt,
    output logic                  a_lost,
    output logic                  b_lost
);
    localparam int PW  = 2*LG + DW + 1;
    localparam int DIR = DW + BIT;

    rr_pick_e ptr_q;
    logic     a_v, b_v, a_dir, b_dir, clash, a_go, b_go;

    // Decode requests and resolve a conflict
    always_comb begin
        a_v    = a_pkt[PW-1];
        b_v    = b_pkt[PW-1];
        a_dir  = a_pkt[DIR];
        b_dir  = b_pkt[DIR];
        clash  = a_v && b_v && (a_dir == b_dir);
        a_go   = a_v && (!clash || (ptr_q == PICK_UPPER));
        b_go   = b_v && (!clash || (ptr_q == PICK_LOWER));
        a_lost = a_v && !a_go;
        b_lost = b_v && !b_go;
    end

    // Drive both element outputs from the granted packets
    always_comb begin
        y0_pkt = '0;
        y1_pkt = '0;
        if (a_go && !a_dir) y0_pkt = a_pkt;
        if (b_go && !b_dir) y0_pkt = b_pkt;
        if (a_go &&  a_dir) y1_pkt = a_pkt;
        if (b_go &&  b_dir) y1_pkt = b_pkt;
    end

    // Round-robin pointer toggles on each resolved conflict
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr_q <= PICK_UPPER;
        else if (clash) ptr_q <= (ptr_q == PICK_UPPER) ? PICK_LOWER : PICK_UPPER;
    end

endmodule

// File: rtl/omega_stage.sv
// Module: one column of the network: shuffle wiring then N/2 elements.
// Column STAGE steers on destination bit LG-1-STAGE. Reports, per source
// port, which packets were dropped in this column.
// Assumes N is a power of two and N == 2**LG.
module omega_stage
    import omega_pkg::*;
#(
    parameter int N     = 8,
    parameter int LG    = 3,
    parameter int DW    = 8,
    parameter int STAGE = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N-1:0][2*LG+DW:0]     lanes_in,
    output logic [N-1:0][2*LG+DW:0]     lanes_out,
    output logic [N-1:0]                lost_src
);
    localparam int HALF   = N / 2;
    localparam int SRC_LO = DW + LG;

    logic [N-1:0][2*LG+DW:0] sh;
    logic [HALF-1:0]         up_lost, dn_lost;

    for (genvar q = 0; q < N; q++) begin : g_shuffle
        assign sh[q] = lanes_in[shuffle_from(q, LG)];
    end

    for (genvar k = 0; k < HALF; k++) begin : g_elem
        omega_switch2 #(.DW(DW), .LG(LG), .BIT(LG - 1 - STAGE)) u_sw (
            .clk    (clk),
            .rst_n  (rst_n),
            .a_pkt  (sh[2*k]),
            .b_pkt  (sh[2*k+1]),
            .y0_pkt (lanes_out[2*k]),
            .y1_pkt (lanes_out[2*k+1]),
            .a_lost (up_lost[k]),
            .b_lost (dn_lost[k])
        );
    end

    // Map dropped packets back to the port they entered on
    always_comb begin
        lost_src = '0;
        for (int k = 0; k < HALF; k++) begin
            if (up_lost[k]) lost_src[sh[2*k][SRC_LO +: LG]]   = 1'b1;
            if (dn_lost[k]) lost_src[sh[2*k+1][SRC_LO +: LG]] = 1'b1;
        end
    end

endmodule

// File: rtl/omega_network.sv
// Module: top of the N x N self-routing shuffle-exchange network.
// Registers inputs, routes through LG combinational columns, registers
// outputs: two cycles of latency. Dropped packets raise in_blocked.
// Assumes N_PORTS is a power of two, at least 2.
module omega_network #(
    parameter int N_PORTS = 8,
    parameter int DATA_W  = 8,
    localparam int LG     = $clog2(N_PORTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_PORTS-1:0]          in_valid,
    input  logic [N_PORTS*LG-1:0]       in_tag,
    input  logic [N_PORTS*DATA_W-1:0]   in_data,
    output logic [N_PORTS-1:0]          out_valid,
    output logic [N_PORTS*DATA_W-1:0]   out_data,
    output logic [N_PORTS-1:0]          in_blocked
);
    localparam int PW = 2*LG + DATA_W + 1;

    logic [LG:0][N_PORTS-1:0][PW-1:0] lane;
    logic [LG-1:0][N_PORTS-1:0]       lost_st;
    logic [N_PORTS-1:0][PW-1:0]       in_q;
    logic [N_PORTS-1:0]               lost_any;

    // Input register: pack packets, clear slots that carry no packet
    always_ff @(posedge clk) begin
        for (int p = 0; p < N_PORTS; p++) begin
            if (!rst_n || !in_valid[p]) in_q[p] <= '0;
            else in_q[p] <= {1'b1, LG'(p), in_tag[p*LG +: LG], in_data[p*DATA_W +: DATA_W]};
        end
    end

    assign lane[0] = in_q;

    for (genvar s = 0; s < LG; s++) begin : g_col
        omega_stage #(.N(N_PORTS), .LG(LG), .DW(DATA_W), .STAGE(s)) u_col (
            .clk       (clk),
            .rst_n     (rst_n),
            .lanes_in  (lane[s]),
            .lanes_out (lane[s+1]),
            .lost_src  (lost_st[s])
        );
    end

    // Collect drops from every column
    always_comb begin
        lost_any = '0;
        for (int s = 0; s < LG; s++) lost_any |= lost_st[s];
    end

    // Output register: arrival flags, payloads and blocked flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= '0;
            out_data   <= '0;
            in_blocked <= '0;
        end else begin
            for (int p = 0; p < N_PORTS; p++) begin
                out_valid[p]                <= lane[LG][p][PW-1];
                out_data[p*DATA_W +: DATA_W] <= lane[LG][p][DATA_W-1:0];
            end
            in_blocked <= lost_any;
        end
    end

endmodule

// File: rtl/omega_network_chk.sv
// Module: assertion checker bound to omega_network.
// Observes ports only; uses a saturating age counter so that two-deep
// history is examined only once it lies after reset.
module omega_network_chk #(
    parameter int N_PORTS = 8,
    parameter int DATA_W  = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [N_PORTS-1:0]          in_valid,
    input logic [N_PORTS-1:0]          out_valid,
    input logic [N_PORTS*DATA_W-1:0]   out_data,
    input logic [N_PORTS-1:0]          in_blocked
);
    logic [1:0] age_q;

    // Count cycles since reset, saturating at two
    always_ff @(posedge clk) begin
        if (!rst_n)           age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0 && in_blocked == '0 && out_data == '0)); // R1

    AST_PACKET_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> ($countones(out_valid) + $countones(in_blocked)
                             == $countones($past(in_valid, 2)))); // R9

    AST_BLOCKED_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> ((in_blocked & ~$past(in_valid, 2)) == '0)); // R7

    AST_IDLE_NO_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && $past(in_valid, 2) == '0) |-> (out_valid == '0)); // R7

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid[p] |-> (out_data[p*DATA_W +: DATA_W] == '0)); // R8
    end

endmodule

bind omega_network omega_network_chk #(.N_PORTS(N_PORTS), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .in_blocked (in_blocked)
);

// File: tb/sim_omega_network.sv
`timescale 1ns/1ps
module sim_omega_network;
    localparam int N  = 8;
    localparam int DW = 8;
    localparam int LG = $clog2(N);
    localparam int HALF = N / 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      in_valid = '0;
    logic [N*LG-1:0]   in_tag = '0;
    logic [N*DW-1:0]   in_data = '0;
    logic [N-1:0]      out_valid;
    logic [N*DW-1:0]   out_data;
    logic [N-1:0]      in_blocked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int         vtag [N];
    logic [N-1:0] vval;
    logic [DW-1:0] vdat [N];
    bit         rr [LG][HALF];
    logic [N-1:0]    exp_valid, exp_blk;
    logic [N*DW-1:0] exp_data;
    int unsigned seed = 32'h1234_5678;

    always #4 clk = ~clk;

    omega_network #(.N_PORTS(N), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
        .in_blocked(in_blocked)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Model: closed-form line positions per column plus pointer per element
    task automatic predict();
        bit alive [N];
        int cur [N];
        int pos [N];
        exp_valid = '0; exp_blk = '0; exp_data = '0;
        for (int p = 0; p < N; p++) begin
            alive[p] = vval[p];
            cur[p]   = p;
        end
        for (int s = 0; s < LG; s++) begin
            for (int p = 0; p < N; p++)
                pos[p] = ((p << (s + 1)) | (vtag[p] >> (LG - 1 - s))) & (N - 1);
            for (int p = 0; p < N; p++) begin
                for (int q = p + 1; q < N; q++) begin
                    if (alive[p] && alive[q] && pos[p] == pos[q]) begin
                        int sw;
                        int ip;
                        bit p_upper;
                        bit p_wins;
                        sw = pos[p] >> 1;
                        ip = ((cur[p] << 1) | (cur[p] >> (LG - 1))) & (N - 1);
                        p_upper = (ip % 2 == 0);
                        p_wins  = (rr[s][sw] == 1'b0) ? p_upper : !p_upper;
                        rr[s][sw] = !rr[s][sw];
                        if (p_wins) begin alive[q] = 1'b0; exp_blk[q] = 1'b1; end
                        else        begin alive[p] = 1'b0; exp_blk[p] = 1'b1; end
                    end
                end
            end
            for (int p = 0; p < N; p++) cur[p] = pos[p];
        end
        for (int p = 0; p < N; p++) begin
            if (alive[p]) begin
                exp_valid[vtag[p]] = 1'b1;
                exp_data[vtag[p]*DW +: DW] = vdat[p];
            end
        end
    endtask

    task automatic drive(input bit with_valid);
        for (int p = 0; p < N; p++) begin
            in_valid[p] = with_valid ? vval[p] : 1'b0;
            in_tag[p*LG +: LG] = LG'(vtag[p]);
            in_data[p*DW +: DW] = vdat[p];
        end
    endtask

    // Apply current vector at a falling edge and check at the due cycles
    task automatic apply_vec(input string tagmsg);
        predict();
        drive(1'b1);
        @(posedge clk); @(negedge clk);
        drive(1'b0);
        chk({"R2 latency ", tagmsg}, {out_valid, in_blocked}, '0);
        @(posedge clk); @(negedge clk);
        chk({"R3 R4 arrival ", tagmsg}, 64'(out_valid), 64'(exp_valid));
        chk({"R3 R8 payload ", tagmsg}, 64'(out_data), 64'(exp_data));
        chk({"R5 R9 blocked ", tagmsg}, 64'(in_blocked), 64'(exp_blk));
    endtask

    task automatic set_all(input logic [N-1:0] v, input int k, input int mode);
        vval = v;
        for (int p = 0; p < N; p++) begin
            case (mode)
                0: vtag[p] = (p + k) % N;
                1: vtag[p] = p ^ k;
                default: vtag[p] = k;
            endcase
            vdat[p] = DW'((k * N + p) * 37 + 5);
        end
    endtask

    initial begin
        for (int s = 0; s < LG; s++)
            for (int k = 0; k < HALF; k++) rr[s][k] = 1'b0;
        for (int p = 0; p < N; p++) begin vtag[p] = 0; vdat[p] = '0; end
        vval = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset outputs", {out_valid, in_blocked}, '0);
        chk("R1 reset data", 64'(out_data), '0);
        rst_n = 1'b1;

        // Conflict-free sweeps: shifts and xor maps
        for (int k = 0; k < N; k++) begin set_all('1, k, 0); apply_vec("shift"); end
        for (int k = 0; k < N; k++) begin set_all('1, k, 1); apply_vec("xor"); end

        // Hot spot: everyone to one output
        for (int k = 0; k < N; k++) begin set_all('1, k, 2); apply_vec("hotspot"); end

        // R6 R7: sources 0 and 4 collide in the first column
        set_all('0, 0, 2);
        vval[0] = 1'b1; vval[4] = 1'b1;
        apply_vec("R6 first conflict");
        chk("R6 upper input wins first", 64'(in_blocked), 64'(8'h10) & 64'(exp_blk));
        vval = '0; vtag[0] = 0; vtag[4] = 0;
        apply_vec("R7 invalid look-alike");
        vval[0] = 1'b1; vval[4] = 1'b1;
        apply_vec("R6 second conflict");
        chk("R6 R7 lower input wins second", 64'(in_blocked), 64'(8'h01));

        // Pseudo-random vectors
        for (int i = 0; i < 400; i++) begin
            for (int p = 0; p < N; p++) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                vtag[p] = int'((seed >> 16) & (N - 1));
                vval[p] = ((seed >> 24) & 3) != 0;
                vdat[p] = DW'(seed >> 8);
            end
            apply_vec("random");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule